// File: doc/BRIEF.md
# Sensor Threshold Alarm Unit

This block watches a stream of 10-bit conversion results from on-chip sensors. Each result arrives with a one-cycle valid strobe and a 2-bit sensor tag. Three tags are monitored: tag 0 is die temperature, tag 1 is the core supply and tag 2 is the auxiliary supply. Each monitored sensor has a programmable upper and lower limit. A sensor's alarm bit reflects whether its most recent reading fell outside that window. The bit drops again by itself when a later reading is back inside the window, so the host never has to acknowledge it. For each sensor the block also keeps the smallest and the largest reading seen since reset.

Temperature readings also drive an over-temperature flag with hysteresis. The flag sets when a reading goes above a trip limit and clears only when a reading goes below a lower release limit. While the flag is set, a power-down request is held high. A single interrupt line is raised while any alarm or the over-temperature flag is active, so readings inside every window produce no interrupt.

Each window alarm is a two-state machine. In WIN_OK, a reading outside the window takes transition GO_OUT to WIN_ALARM. In WIN_ALARM, a reading inside the window takes transition GO_IN back to WIN_OK. The over-temperature logic is also a two-state machine. In OT_COOL, a temperature reading above the trip limit takes transition TRIP to OT_HOT. In OT_HOT, a temperature reading below the release limit takes transition RELEASE back to OT_COOL. Any other event leaves both machines where they are.

Top module: `sensor_alarm_unit`

## Requirements
- R1: After reset the block holds these values: `alarm` = 0, `ot_flag` = 0, `pdown_req` = 0 and `irq` = 0. Every minimum field reads 3FFh and every maximum field reads 000h. The window limits reset to lower 000h and upper 3FFh, and the over-temperature trip and release limits reset to 3FFh and 000h.
- R2: A valid reading takes effect at the clock edge where `meas_valid` is sampled high, and the outputs show the result from that edge on. For sensor i (i = `meas_id`), the reading sets `alarm[i]` when the code is strictly above that sensor's upper limit or strictly below its lower limit. A code equal to either limit counts as in range.
- R3: An alarm bit clears at the next valid reading for its sensor that lies inside the window, with no acknowledge.
- R4: `ot_flag` and `pdown_req` set together on a tag-0 reading whose code is strictly above the trip limit. A code equal to the trip limit does not set them.
- R5: Once set, `ot_flag` and `pdown_req` stay high until a tag-0 reading is strictly below the release limit. Readings equal to the release limit, readings between the two limits, and readings for other tags leave the flag set.
- R6: Each sensor's minimum field takes min(stored, code) and its maximum field takes max(stored, code) on each of that sensor's readings. Sensor i occupies bits [10*i+9:10*i] of `min_vals` and of `max_vals`.
- R7: A reading with tag 3 changes no output. A reading for one sensor leaves the alarm bit, minimum field and maximum field of every other sensor unchanged.
- R8: `irq` is high exactly when some `alarm` bit or `ot_flag` is high.
- R9: A limit write does not change any alarm by itself. The new limits apply from the next reading on. A window write with `lim_we` loads `lim_hi`/`lim_lo` for sensor `lim_sel`, and an over-temperature write with `ot_we` loads `ot_trip`/`ot_release`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 1 | One-cycle strobe for a reading |
| meas_id | input | 2 | Sensor tag (0 temperature, 1 core supply, 2 auxiliary supply, 3 unmonitored) |
| meas_code | input | 10 | Converted reading |
| lim_we | input | 1 | Window limit write enable |
| lim_sel | input | 2 | Sensor whose window is written |
| lim_hi | input | 10 | Upper limit value to write |
| lim_lo | input | 10 | Lower limit value to write |
| ot_we | input | 1 | Over-temperature limit write enable |
| ot_trip | input | 10 | Trip limit value to write |
| ot_release | input | 10 | Release limit value to write |
| alarm | output | 3 | Per-sensor window alarm |
| ot_flag | output | 1 | Over-temperature flag |
| pdown_req | output | 1 | Power-down request |
| irq | output | 1 | Host interrupt |
| min_vals | output | 30 | Packed per-sensor minimum readings |
| max_vals | output | 30 | Packed per-sensor maximum readings |

## Verification
Window alarms are tested with readings just inside and on each limit, and with readings one code beyond each limit. This separates strict comparisons from non-strict ones and shows that the alarm clears by itself. A limit rewrite followed first by a check and then by a fresh reading shows that the alarm state moves only on readings. The hysteresis test sweeps the temperature through the trip value, the band between the two limits, the release value and one code below it. It also sends a reading with another tag while the flag is set. Tag-3 readings and readings for neighbouring sensors are compared against a snapshot of all outputs, and the minimum and maximum fields are checked after sequences that move each of them.

// File: rtl/sam_pkg.sv
package sam_pkg;
    localparam int CODE_W   = 10;
    localparam int ID_W     = 2;
    localparam int NUM_SENS = 3;
    localparam int TEMP_ID  = 0;

    typedef enum logic {WIN_OK, WIN_ALARM} win_state_e;
    typedef enum logic {OT_COOL, OT_HOT} ot_state_e;
endpackage

// File: rtl/sam_window.sv
module sam_window
    import sam_pkg::*;
#(
    parameter int CW  = CODE_W,
    parameter int IW  = ID_W,
    parameter int IDX = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          meas_valid,
    input  logic [IW-1:0] meas_id,
    input  logic [CW-1:0] meas_code,
    input  logic [CW-1:0] lim_hi,
    input  logic [CW-1:0] lim_lo,
    output logic          alarm,
    output logic [CW-1:0] min_val,
    output logic [CW-1:0] max_val
);
    localparam logic [IW-1:0] MY_ID   = IW'(IDX);
    localparam logic [CW-1:0] CODE_HI = {CW{1'b1}};

    win_state_e state_q, state_d;
    logic       hit, outside;

    assign hit     = meas_valid && (meas_id == MY_ID);
    assign outside = (meas_code > lim_hi) || (meas_code < lim_lo);

    // next-state: GO_OUT and GO_IN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_OK:    if (hit && outside)  state_d = WIN_ALARM;
            WIN_ALARM: if (hit && !outside) state_d = WIN_OK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WIN_OK;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_val <= CODE_HI;
            max_val <= '0;
        end else if (hit) begin
            if (meas_code < min_val) min_val <= meas_code;
            if (meas_code > max_val) max_val <= meas_code;
        end
    end

    always_comb alarm = (state_q == WIN_ALARM);

    // checker state: has any reading arrived for this sensor
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   seen_q <= 1'b0;
        else if (hit) seen_q <= 1'b1;
    end

    a_r7_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(alarm) && $stable(min_val) && $stable(max_val)));
    a_r6_min_not_above_max: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (min_val <= max_val));
    a_r2_rise_needs_outside: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> ($past(meas_code) > $past(lim_hi) || $past(meas_code) < $past(lim_lo)));
    a_r3_fall_needs_inside: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm) |-> ($past(meas_code) <= $past(lim_hi) && $past(meas_code) >= $past(lim_lo)));
endmodule

// File: rtl/sam_ot.sv
module sam_ot
    import sam_pkg::*;
#(
    parameter int CW  = CODE_W,
    parameter int IW  = ID_W,
    parameter int TID = TEMP_ID
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          meas_valid,
    input  logic [IW-1:0] meas_id,
    input  logic [CW-1:0] meas_code,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_trip,
    input  logic [CW-1:0] cfg_release,
    output logic          ot_flag,
    output logic          pdown_req
);
    localparam logic [IW-1:0] T_ID = IW'(TID);

    ot_state_e     state_q, state_d;
    logic [CW-1:0] trip_q, rel_q;
    logic          temp_hit;

    assign temp_hit = meas_valid && (meas_id == T_ID);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trip_q <= {CW{1'b1}};
            rel_q  <= '0;
        end else if (cfg_we) begin
            trip_q <= cfg_trip;
            rel_q  <= cfg_release;
        end
    end

    // next-state: TRIP and RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OT_COOL: if (temp_hit && (meas_code > trip_q)) state_d = OT_HOT;
            OT_HOT:  if (temp_hit && (meas_code < rel_q))  state_d = OT_COOL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OT_COOL;
        else        state_q <= state_d;
    end

    always_comb begin
        ot_flag   = (state_q == OT_HOT);
        pdown_req = (state_q == OT_HOT);
    end

    a_r4_trip_strict: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ot_flag) |-> ($past(meas_code) > $past(trip_q)));
    a_r5_release_strict: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ot_flag) |-> ($past(meas_code) < $past(rel_q) && $past(meas_id) == T_ID));
    a_r5_hot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_flag && !temp_hit) |=> ot_flag);
endmodule

// File: rtl/sensor_alarm_unit.sv
module sensor_alarm_unit
    import sam_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int IW = ID_W,
    parameter int NS = NUM_SENS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           meas_valid,
    input  logic [IW-1:0]  meas_id,
    input  logic [CW-1:0]  meas_code,
    input  logic           lim_we,
    input  logic [IW-1:0]  lim_sel,
    input  logic [CW-1:0]  lim_hi,
    input  logic [CW-1:0]  lim_lo,
    input  logic           ot_we,
    input  logic [CW-1:0]  ot_trip,
    input  logic [CW-1:0]  ot_release,
    output logic [NS-1:0]  alarm,
    output logic           ot_flag,
    output logic           pdown_req,
    output logic           irq,
    output logic [NS*CW-1:0] min_vals,
    output logic [NS*CW-1:0] max_vals
);
    for (genvar i = 0; i < NS; i++) begin : g_sens
        logic [CW-1:0] hi_q, lo_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_q <= {CW{1'b1}};
                lo_q <= '0;
            end else if (lim_we && (lim_sel == IW'(i))) begin
                hi_q <= lim_hi;
                lo_q <= lim_lo;
            end
        end

        sam_window #(.CW(CW), .IW(IW), .IDX(i)) u_win (
            .clk        (clk),
            .rst_n      (rst_n),
            .meas_valid (meas_valid),
            .meas_id    (meas_id),
            .meas_code  (meas_code),
            .lim_hi     (hi_q),
            .lim_lo     (lo_q),
            .alarm      (alarm[i]),
            .min_val    (min_vals[i*CW +: CW]),
            .max_val    (max_vals[i*CW +: CW])
        );
    end

    sam_ot #(.CW(CW), .IW(IW), .TID(TEMP_ID)) u_ot (
        .clk         (clk),
        .rst_n       (rst_n),
        .meas_valid  (meas_valid),
        .meas_id     (meas_id),
        .meas_code   (meas_code),
        .cfg_we      (ot_we),
        .cfg_trip    (ot_trip),
        .cfg_release (ot_release),
        .ot_flag     (ot_flag),
        .pdown_req   (pdown_req)
    );

    always_comb irq = (|alarm) || ot_flag;

    a_r8_irq_after_reading: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(meas_valid));
    a_r9_write_no_alarm_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |=> !$rose(irq));
endmodule

// File: tb/sensor_alarm_unit_bench.sv
module sensor_alarm_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        meas_valid = 1'b0;
    logic [1:0]  meas_id = '0;
    logic [9:0]  meas_code = '0;
    logic        lim_we = 1'b0;
    logic [1:0]  lim_sel = '0;
    logic [9:0]  lim_hi = '0, lim_lo = '0;
    logic        ot_we = 1'b0;
    logic [9:0]  ot_trip = '0, ot_release = '0;
    logic [2:0]  alarm;
    logic        ot_flag, pdown_req, irq;
    logic [29:0] min_vals, max_vals;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sensor_alarm_unit u_sensor_alarm_unit (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_id(meas_id),
        .meas_code(meas_code), .lim_we(lim_we), .lim_sel(lim_sel), .lim_hi(lim_hi),
        .lim_lo(lim_lo), .ot_we(ot_we), .ot_trip(ot_trip), .ot_release(ot_release),
        .alarm(alarm), .ot_flag(ot_flag), .pdown_req(pdown_req), .irq(irq),
        .min_vals(min_vals), .max_vals(max_vals)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // drive on falling edge, one rising edge samples it, result visible at next falling edge
    task automatic sample(input logic [1:0] id, input logic [9:0] code);
        @(negedge clk);
        meas_valid = 1'b1; meas_id = id; meas_code = code;
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    task automatic set_window(input logic [1:0] s, input logic [9:0] lo, input logic [9:0] hi);
        @(negedge clk);
        lim_we = 1'b1; lim_sel = s; lim_lo = lo; lim_hi = hi;
        @(negedge clk);
        lim_we = 1'b0;
    endtask

    task automatic set_ot(input logic [9:0] trip, input logic [9:0] rel);
        @(negedge clk);
        ot_we = 1'b1; ot_trip = trip; ot_release = rel;
        @(negedge clk);
        ot_we = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 alarm", 32'(alarm), 0);
        check("R1 ot_flag", 32'(ot_flag), 0);
        check("R1 pdown_req", 32'(pdown_req), 0);
        check("R1 irq", 32'(irq), 0);
        for (int i = 0; i < 3; i++) begin
            check("R1 min", 32'(min_vals[i*10 +: 10]), 32'h3ff);
            check("R1 max", 32'(max_vals[i*10 +: 10]), 0);
        end
        sample(2'd1, 10'd500);   // default window 0..3FF: in range
        check("R1 default window no alarm", 32'(alarm), 0);
    endtask

    task automatic t_window;
        set_window(2'd1, 10'd100, 10'd200);
        sample(2'd1, 10'd150); check("R2 inside", 32'(alarm[1]), 0);
        sample(2'd1, 10'd200); check("R2 equal upper", 32'(alarm[1]), 0);
        sample(2'd1, 10'd201); check("R2 above upper", 32'(alarm[1]), 1);
        check("R8 irq on alarm", 32'(irq), 1);
        sample(2'd1, 10'd100); check("R3 clear at lower", 32'(alarm[1]), 0);
        check("R8 irq quiet", 32'(irq), 0);
        sample(2'd1, 10'd99);  check("R2 below lower", 32'(alarm[1]), 1);
        sample(2'd1, 10'd150); check("R3 self clear", 32'(alarm[1]), 0);
        check("R6 min s1", 32'(min_vals[19:10]), 99);
        check("R6 max s1", 32'(max_vals[19:10]), 500);
    endtask

    task automatic t_rewrite;
        set_window(2'd2, 10'd0, 10'd50);
        sample(2'd2, 10'd40); check("R2 s2 inside", 32'(alarm[2]), 0);
        set_window(2'd2, 10'd0, 10'd30);
        repeat (2) @(negedge clk);
        check("R9 write alone", 32'(alarm[2]), 0);
        sample(2'd2, 10'd40); check("R9 new limit used", 32'(alarm[2]), 1);
        sample(2'd2, 10'd20); check("R3 s2 clear", 32'(alarm[2]), 0);
        check("R6 min s2", 32'(min_vals[29:20]), 20);
        check("R6 max s2", 32'(max_vals[29:20]), 40);
    endtask

    task automatic t_ignore;
        logic [2:0]  a0;
        logic [29:0] mn, mx;
        a0 = alarm; mn = min_vals; mx = max_vals;
        sample(2'd3, 10'd1023);
        check("R7 tag3 alarm", 32'(alarm), 32'(a0));
        check("R7 tag3 min", 32'(min_vals), 32'(mn));
        check("R7 tag3 max", 32'(max_vals), 32'(mx));
        check("R7 tag3 ot", 32'(ot_flag), 0);
        sample(2'd2, 10'd1000);
        check("R7 neighbour s1 alarm", 32'(alarm[1]), 0);
        check("R7 neighbour s1 max", 32'(max_vals[19:10]), 32'(mx[19:10]));
        check("R7 neighbour s0 min", 32'(min_vals[9:0]), 32'h3ff);
        sample(2'd2, 10'd10);
    endtask

    task automatic t_ot;
        set_ot(10'd800, 10'd700);
        check("R9 ot write alone", 32'(ot_flag), 0);
        sample(2'd0, 10'd800); check("R4 equal trip", 32'(ot_flag), 0);
        sample(2'd0, 10'd801); check("R4 above trip", 32'(ot_flag), 1);
        check("R4 pdown", 32'(pdown_req), 1);
        check("R8 irq on ot", 32'(irq), 1);
        check("R8 window clear during ot", 32'(alarm), 0);
        sample(2'd1, 10'd150); check("R5 other tag", 32'(ot_flag), 1);
        sample(2'd0, 10'd750); check("R5 in band", 32'(ot_flag), 1);
        sample(2'd0, 10'd700); check("R5 equal release", 32'(ot_flag), 1);
        sample(2'd0, 10'd699); check("R5 below release", 32'(ot_flag), 0);
        check("R5 pdown off", 32'(pdown_req), 0);
        check("R8 irq off", 32'(irq), 0);
        check("R6 min s0", 32'(min_vals[9:0]), 699);
        check("R6 max s0", 32'(max_vals[9:0]), 801);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_window;
        t_rewrite;
        t_ignore;
        t_ot;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule